// File: doc/BRIEF.md
# Switch Control Source Selector

This block sits beside a three-channel signal switch and decides where each of the switch's control lines gets its value. A mode input picks one of two regimes. With the mode input low, every control comes straight from the external pins. With the mode input high, each channel's equalization and pre-emphasis come from registers. Each switching control (per-channel loopback, select, broadcast) is then steered to either its pin or its register bit by a dedicated mask bit.

Software reaches the registers through a plain synchronous port: address, write data, write enable and registered read data. The resolved control outputs are combinational from the register contents, the mask, the mode input and the pins. A register write therefore shows on the outputs in the cycle right after the clock edge that accepts it.

Top module: `swctl_source_sel`

## Requirements
- R1: After reset every register holds 0x00, and reading any address returns 0x00.
- R2: With mode_i low, loop_o, sel_o, bcast_o, eq_o and pe_o equal their pin inputs, whatever the registers hold.
- R3: With mode_i high, eq_o and pe_o are taken from the channel registers only, and their pins have no effect.
- R4: With mode_i high, mask register 0x00 picks the source of each switching control. Bit 0, bit 1 and bit 2 control loopback of channels A, B and C. Bit 3 controls select and bit 4 controls broadcast. A mask bit of 0 selects the pin and a mask bit of 1 selects the register bit. With 0x1F every switching control comes from registers. With 0x0C only select and loopback C do.
- R5: Channel registers 0x01, 0x02 and 0x03 serve channels A, B and C. In each one, bit 4 is output disable, bit 3 is loopback, bit 2 is equalization and bits 1:0 are pre-emphasis. Channel c drives pe_o[2c+1:2c] and bit c of loop_o, eq_o and out_en_o.
- R6: Register 0x04 holds broadcast at bit 1 and select at bit 0.
- R7: With mode_i high, out_en_o[c] is the inverse of channel c's disable bit. With mode_i low, out_en_o is all ones.
- R8: Register bits above the defined fields ignore writes and read as zero. After a write of 0xFF, mask reads back 0x1F.
- R9: Writes to addresses above 0x04 change no register, and reads there return 0x00.
- R10: rdata_o shows the contents of the addressed register as they were at the sampling clock edge, one cycle after the address is presented. A write accepted at an edge appears on the resolved outputs straight after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0: all controls from pins; 1: register/mixed control |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Register write data |
| we_i | input | 1 | Write enable |
| rdata_o | output | 8 | Registered read data |
| pin_loop_i | input | 3 | Loopback pins, bit c for channel c |
| pin_sel_i | input | 1 | Select pin |
| pin_bcast_i | input | 1 | Broadcast pin |
| pin_eq_i | input | 3 | Equalization pins |
| pin_pe_i | input | 6 | Pre-emphasis pins, two bits per channel |
| loop_o | output | 3 | Resolved loopback |
| sel_o | output | 1 | Resolved select |
| bcast_o | output | 1 | Resolved broadcast |
| eq_o | output | 3 | Resolved equalization |
| pe_o | output | 6 | Resolved pre-emphasis |
| out_en_o | output | 3 | Resolved output enable |

## Verification
The directed tests hold the pins at values that differ from the register bits. This shows whether each output comes from its pin or its register, under mask values 0x0C and 0x1F and in both modes. Over-wide writes, writes outside 0x00 to 0x04 and a write and read to the same address in one cycle separate a correct field layout from a mis-decoded one. A long random run then toggles the mode, the pins, the mask and the register contents every cycle against a behavioural model. This exposes any control that uses the wrong mask bit or ignores the mode.

// File: rtl/swctl_pkg.sv
package swctl_pkg;

  localparam int unsigned PE_W = 2;

  // channel register field positions
  localparam int unsigned CH_DIS_BIT  = 4;
  localparam int unsigned CH_LOOP_BIT = 3;
  localparam int unsigned CH_EQ_BIT   = 2;

  // global register field positions
  localparam int unsigned GLB_SEL_BIT   = 0;
  localparam int unsigned GLB_BCAST_BIT = 1;
  localparam int unsigned GLB_BITS      = 2;

  localparam int unsigned MASK_ADDR = 0;

  typedef struct packed {
    logic            dis;
    logic            loop;
    logic            eq;
    logic [PE_W-1:0] pe;
  } chan_cfg_t;

  localparam int unsigned CH_BITS = $bits(chan_cfg_t);

endpackage

// File: rtl/swctl_regs.sv
module swctl_regs
  import swctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic                      we_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [NUM_CH+1:0]         mask_o,
  output chan_cfg_t [NUM_CH-1:0]    chan_o,
  output logic                      reg_sel_o,
  output logic                      reg_bcast_o
);

  localparam int unsigned MASK_W    = NUM_CH + 2;
  localparam int unsigned GLOB_ADDR = NUM_CH + 1;
  localparam int unsigned USED_W    = (MASK_W > CH_BITS) ? MASK_W : CH_BITS;

  logic [MASK_W-1:0]      mask_q;
  chan_cfg_t [NUM_CH-1:0] chan_q;
  logic [GLOB_BITS_W-1:0] glob_q;
  logic [DATA_W-1:0]      rd_next;

  localparam int unsigned GLOB_BITS_W = GLB_BITS;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:USED_W];

  // mask register
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (we_i && addr_i == ADDR_W'(MASK_ADDR)) begin
      mask_q <= wdata_i[MASK_W-1:0];
    end
  end

  // one register per channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        chan_q[c] <= '0;
      end else if (we_i && addr_i == ADDR_W'(c + 1)) begin
        chan_q[c] <= chan_cfg_t'(wdata_i[CH_BITS-1:0]);
      end
    end
  end

  // global switching register
  always_ff @(posedge clk) begin
    if (rst) begin
      glob_q <= '0;
    end else if (we_i && addr_i == ADDR_W'(GLOB_ADDR)) begin
      glob_q <= wdata_i[GLOB_BITS_W-1:0];
    end
  end

  // read mux, registered below
  always_comb begin
    rd_next = '0;
    if (addr_i == ADDR_W'(MASK_ADDR)) begin
      rd_next[MASK_W-1:0] = mask_q;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(c + 1)) begin
        rd_next[CH_BITS-1:0] = chan_q[c];
      end
    end
    if (addr_i == ADDR_W'(GLOB_ADDR)) begin
      rd_next[GLOB_BITS_W-1:0] = glob_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= rd_next;
    end
  end

  assign mask_o      = mask_q;
  assign chan_o      = chan_q;
  assign reg_sel_o   = glob_q[GLB_SEL_BIT];
  assign reg_bcast_o = glob_q[GLB_BCAST_BIT];

  // R1: first read after reset release returns zero
  a_r1_released_read_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rdata_o == '0);

  // R8: bits above the widest field always read zero
  a_r8_upper_read_zero: assert property (@(posedge clk) disable iff (rst)
    rdata_o[DATA_W-1:USED_W] == '0);

  // R9: out-of-range writes leave every register untouched
  a_r9_high_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i > ADDR_W'(GLOB_ADDR)) |=>
      ($stable(mask_q) && $stable(chan_q) && $stable(glob_q)));

  // R9: out-of-range reads return zero
  a_r9_high_read_zero: assert property (@(posedge clk) disable iff (rst)
    (addr_i > ADDR_W'(GLOB_ADDR)) |=> rdata_o == '0);

  // R10: a global write is in place one edge later
  a_r10_glob_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i == ADDR_W'(GLOB_ADDR)) |=>
      {reg_bcast_o, reg_sel_o} == $past(wdata_i[GLOB_BITS_W-1:0]));

endmodule

// File: rtl/swctl_pick.sv
module swctl_pick #(
  parameter int unsigned W = 1
) (
  input  logic         use_reg_i,
  input  logic [W-1:0] reg_val_i,
  input  logic [W-1:0] pin_val_i,
  output logic [W-1:0] val_o
);

  assign val_o = use_reg_i ? reg_val_i : pin_val_i;

endmodule

// File: rtl/swctl_resolve.sv
module swctl_resolve
  import swctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode_i,
  input  logic [NUM_CH+1:0]        mask_i,
  input  chan_cfg_t [NUM_CH-1:0]   chan_i,
  input  logic                     reg_sel_i,
  input  logic                     reg_bcast_i,
  input  logic [NUM_CH-1:0]        pin_loop_i,
  input  logic                     pin_sel_i,
  input  logic                     pin_bcast_i,
  input  logic [NUM_CH-1:0]        pin_eq_i,
  input  logic [NUM_CH*PE_W-1:0]   pin_pe_i,
  output logic [NUM_CH-1:0]        loop_o,
  output logic                     sel_o,
  output logic                     bcast_o,
  output logic [NUM_CH-1:0]        eq_o,
  output logic [NUM_CH*PE_W-1:0]   pe_o,
  output logic [NUM_CH-1:0]        out_en_o
);

  localparam int unsigned SEL_MBIT   = NUM_CH;
  localparam int unsigned BCAST_MBIT = NUM_CH + 1;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    swctl_pick #(.W(1)) u_loop (
      .use_reg_i (mode_i & mask_i[c]),
      .reg_val_i (chan_i[c].loop),
      .pin_val_i (pin_loop_i[c]),
      .val_o     (loop_o[c])
    );
    swctl_pick #(.W(1)) u_eq (
      .use_reg_i (mode_i),
      .reg_val_i (chan_i[c].eq),
      .pin_val_i (pin_eq_i[c]),
      .val_o     (eq_o[c])
    );
    swctl_pick #(.W(PE_W)) u_pe (
      .use_reg_i (mode_i),
      .reg_val_i (chan_i[c].pe),
      .pin_val_i (pin_pe_i[c*PE_W +: PE_W]),
      .val_o     (pe_o[c*PE_W +: PE_W])
    );
    swctl_pick #(.W(1)) u_en (
      .use_reg_i (mode_i),
      .reg_val_i (~chan_i[c].dis),
      .pin_val_i (1'b1),
      .val_o     (out_en_o[c])
    );
  end

  swctl_pick #(.W(1)) u_sel (
    .use_reg_i (mode_i & mask_i[SEL_MBIT]),
    .reg_val_i (reg_sel_i),
    .pin_val_i (pin_sel_i),
    .val_o     (sel_o)
  );

  swctl_pick #(.W(1)) u_bcast (
    .use_reg_i (mode_i & mask_i[BCAST_MBIT]),
    .reg_val_i (reg_bcast_i),
    .pin_val_i (pin_bcast_i),
    .val_o     (bcast_o)
  );

  // R2: pin mode passes every pin through
  a_r2_pin_mode_passthru: assert property (@(posedge clk) disable iff (rst)
    !mode_i |-> (loop_o == pin_loop_i && sel_o == pin_sel_i &&
                 bcast_o == pin_bcast_i && eq_o == pin_eq_i && pe_o == pin_pe_i));

  // R7: pin mode keeps all outputs enabled
  a_r7_pin_mode_enabled: assert property (@(posedge clk) disable iff (rst)
    !mode_i |-> (&out_en_o));

  // R4: unmasked loopback lines still follow their pins in register mode
  a_r4_unmasked_loop_pin: assert property (@(posedge clk) disable iff (rst)
    mode_i |-> ((loop_o & ~mask_i[NUM_CH-1:0]) == (pin_loop_i & ~mask_i[NUM_CH-1:0])));

  // R3: in register mode equalization does not move while only pins change
  a_r3_eq_ignores_pins: assert property (@(posedge clk) disable iff (rst)
    (mode_i && $past(mode_i) && $stable(chan_i)) |-> $stable(eq_o));

endmodule

// File: rtl/swctl_source_sel.sv
module swctl_source_sel
  import swctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     we_i,
  output logic [DATA_W-1:0]        rdata_o,
  input  logic [NUM_CH-1:0]        pin_loop_i,
  input  logic                     pin_sel_i,
  input  logic                     pin_bcast_i,
  input  logic [NUM_CH-1:0]        pin_eq_i,
  input  logic [NUM_CH*PE_W-1:0]   pin_pe_i,
  output logic [NUM_CH-1:0]        loop_o,
  output logic                     sel_o,
  output logic                     bcast_o,
  output logic [NUM_CH-1:0]        eq_o,
  output logic [NUM_CH*PE_W-1:0]   pe_o,
  output logic [NUM_CH-1:0]        out_en_o
);

  localparam int unsigned MASK_W = NUM_CH + 2;

  logic [MASK_W-1:0]      mask;
  chan_cfg_t [NUM_CH-1:0] chan;
  logic                   reg_sel;
  logic                   reg_bcast;

  swctl_regs #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .we_i        (we_i),
    .rdata_o     (rdata_o),
    .mask_o      (mask),
    .chan_o      (chan),
    .reg_sel_o   (reg_sel),
    .reg_bcast_o (reg_bcast)
  );

  swctl_resolve #(
    .NUM_CH (NUM_CH)
  ) u_resolve (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .mask_i      (mask),
    .chan_i      (chan),
    .reg_sel_i   (reg_sel),
    .reg_bcast_i (reg_bcast),
    .pin_loop_i  (pin_loop_i),
    .pin_sel_i   (pin_sel_i),
    .pin_bcast_i (pin_bcast_i),
    .pin_eq_i    (pin_eq_i),
    .pin_pe_i    (pin_pe_i),
    .loop_o      (loop_o),
    .sel_o       (sel_o),
    .bcast_o     (bcast_o),
    .eq_o        (eq_o),
    .pe_o        (pe_o),
    .out_en_o    (out_en_o)
  );

endmodule

// File: tb/swctl_source_sel_tb.sv
`timescale 1ns/1ps
module swctl_source_sel_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic [2:0] pin_loop = '0;
  logic       pin_sel = 1'b0;
  logic       pin_bcast = 1'b0;
  logic [2:0] pin_eq = '0;
  logic [5:0] pin_pe = '0;
  logic [2:0] loop_o;
  logic       sel_o;
  logic       bcast_o;
  logic [2:0] eq_o;
  logic [5:0] pe_o;
  logic [2:0] out_en;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural model state
  int regs[5];
  int exp_rd = 0;

  always #2.5 clk = ~clk;

  swctl_source_sel dut_i (
    .clk (clk), .rst (rst), .mode_i (mode), .addr_i (addr), .wdata_i (wdata),
    .we_i (we), .rdata_o (rdata), .pin_loop_i (pin_loop), .pin_sel_i (pin_sel),
    .pin_bcast_i (pin_bcast), .pin_eq_i (pin_eq), .pin_pe_i (pin_pe),
    .loop_o (loop_o), .sel_o (sel_o), .bcast_o (bcast_o), .eq_o (eq_o),
    .pe_o (pe_o), .out_en_o (out_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int valid_bits(input int a);
    if (a == 4) return 'h03;
    return 'h1F;
  endfunction

  // compare every output with the model at the falling edge
  task automatic compare_all();
    logic [2:0] e_loop, e_eq, e_en;
    logic [5:0] e_pe;
    logic e_sel, e_bcast;
    for (int c = 0; c < 3; c++) begin
      int r = regs[c + 1];
      if (mode) begin
        e_loop[c] = regs[0][c] ? r[3] : pin_loop[c];
        e_eq[c] = r[2];
        e_pe[c*2 +: 2] = r[1:0];
        e_en[c] = ~r[4];
      end else begin
        e_loop[c] = pin_loop[c];
        e_eq[c] = pin_eq[c];
        e_pe[c*2 +: 2] = pin_pe[c*2 +: 2];
        e_en[c] = 1'b1;
      end
    end
    e_sel = (mode && regs[0][3]) ? regs[4][0] : pin_sel;
    e_bcast = (mode && regs[0][4]) ? regs[4][1] : pin_bcast;
    check(mode ? "R4 loop" : "R2 loop", 32'(loop_o), 32'(e_loop));
    check(mode ? "R4 sel" : "R2 sel", 32'(sel_o), 32'(e_sel));
    check(mode ? "R4 bcast" : "R2 bcast", 32'(bcast_o), 32'(e_bcast));
    check(mode ? "R3 eq" : "R2 eq", 32'(eq_o), 32'(e_eq));
    check(mode ? "R3 pe" : "R2 pe", 32'(pe_o), 32'(e_pe));
    check("R7 out_en", 32'(out_en), 32'(e_en));
    check("R10 rdata", 32'(rdata), 32'(exp_rd));
  endtask

  // drive one cycle, advance the model at the edge, compare at the falling edge
  task automatic tick(input logic w, input logic [7:0] a, input logic [7:0] d);
    we = w; addr = a; wdata = d;
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 5; i++) regs[i] = 0;
      exp_rd = 0;
    end else begin
      exp_rd = (a <= 4) ? regs[a] : 0;
      if (w && a <= 4) regs[a] = int'(d) & valid_bits(int'(a));
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) regs[i] = 0;
    for (int i = 0; i < 4; i++) tick(1'b1, 8'h00, 8'hFF);
    rst = 1'b0;

    // R1: every address reads zero after reset
    for (int a = 0; a < 6; a++) begin
      tick(1'b0, 8'(a), 8'h00);
      check("R1 reset read", 32'(rdata), 32'h0);
    end

    // pins deliberately differ from register contents
    mode = 1'b1;
    pin_loop = 3'b101; pin_sel = 1'b1; pin_bcast = 1'b1;
    pin_eq = 3'b010; pin_pe = 6'b100111;

    // R4: mask 0x0C puts only select and loopback C on registers
    tick(1'b1, 8'h00, 8'h0C);
    check("R4 mask0C loop", 32'(loop_o), 32'b001);
    check("R4 mask0C sel", 32'(sel_o), 32'h0);
    check("R4 mask0C bcast", 32'(bcast_o), 32'h1);

    // R8: over-wide mask write keeps only five bits
    tick(1'b1, 8'h00, 8'hFF);
    check("R4 mask1F loop", 32'(loop_o), 32'b000);
    check("R4 mask1F bcast", 32'(bcast_o), 32'h0);
    tick(1'b0, 8'h00, 8'h00);
    check("R8 mask readback", 32'(rdata), 32'h1F);

    // R5: channel B register 0xEB -> loop=1 eq=0 pe=3 dis=0
    tick(1'b1, 8'h02, 8'hEB);
    check("R5 loop B", 32'(loop_o), 32'b010);
    check("R5 eq B", 32'(eq_o[1]), 32'h0);
    check("R5 pe B", 32'(pe_o[3:2]), 32'h3);
    check("R3 eq A from reg", 32'(eq_o[0]), 32'h0);
    tick(1'b0, 8'h02, 8'h00);
    check("R8 chan readback", 32'(rdata), 32'h0B);

    // R7: disable A in register mode, enable forced in pin mode
    tick(1'b1, 8'h01, 8'h10);
    check("R7 disable A", 32'(out_en), 32'b110);
    mode = 1'b0;
    tick(1'b0, 8'h00, 8'h00);
    check("R7 pin mode enable", 32'(out_en), 32'b111);
    check("R2 loop pins", 32'(loop_o), 32'b101);
    check("R2 pe pins", 32'(pe_o), 32'b100111);
    mode = 1'b1;

    // R6: global register, 0xFE -> bcast=1 sel=0
    tick(1'b1, 8'h04, 8'hFE);
    check("R6 bcast", 32'(bcast_o), 32'h1);
    check("R6 sel", 32'(sel_o), 32'h0);
    tick(1'b0, 8'h04, 8'h00);
    check("R6 readback", 32'(rdata), 32'h02);

    // R9: out-of-range accesses
    tick(1'b1, 8'h05, 8'hFF);
    tick(1'b1, 8'hFF, 8'h1F);
    tick(1'b0, 8'h05, 8'h00);
    check("R9 high read", 32'(rdata), 32'h0);
    tick(1'b0, 8'h00, 8'h00);
    check("R9 mask unchanged", 32'(rdata), 32'h1F);
    tick(1'b0, 8'h04, 8'h00);
    check("R9 glob unchanged", 32'(rdata), 32'h02);

    // R10: write and read one address in the same cycle
    tick(1'b1, 8'h03, 8'h05);
    check("R10 old data read", 32'(rdata), 32'h0);
    check("R10 eq C visible", 32'(eq_o[2]), 32'h1);
    tick(1'b0, 8'h03, 8'h00);
    check("R10 new data read", 32'(rdata), 32'h05);

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      mode = $urandom_range(0, 3) != 0;
      pin_loop = 3'($urandom); pin_sel = 1'($urandom); pin_bcast = 1'($urandom);
      pin_eq = 3'($urandom); pin_pe = 6'($urandom);
      tick(1'($urandom), 8'($urandom_range(0, 6)), 8'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule